// File: doc/BRIEF.md
# Delayed-Coincidence Decay Trigger

This block watches three detector planes stacked top, middle and bottom, each reporting hits as a synchronous, active-high logic level that only marks whether a hit is present. It looks for a particle that crosses the top and middle planes together and stops before reaching the bottom plane. It then accepts a later hit from the decay product in the middle or bottom plane.

Operation has two phases. First a short prompt window, a few cycles wide, is opened by the first top or middle hit. The window is wide enough to absorb the time-of-flight lag between the two upper planes, and any bottom-plane activity inside it rejects the candidate. A valid candidate opens a long acceptance window, sized in cycles to several mean decay times, and the block waits there for the delayed hit. If that hit arrives between a minimum and a maximum delay, the block emits a single-cycle trigger and reports how many cycles passed since the prompt window opened. Otherwise the block drops back to idle without a trigger.

Top module: `decay_trigger`

## Requirements
- R1: The prompt window opens in the first idle cycle in which `hitTop` or `hitMid` is high (call it cycle t0) and covers cycles t0 to t0+COINC_WIN-1. The candidate is valid only if both `hitTop` and `hitMid` are high in at least one cycle of that window. If a middle hit first appears at t0+COINC_WIN or later, it is not paired with the top hit.
- R2: A `hitBot` high in any cycle of the prompt window rejects the candidate, and no trigger follows. A bottom hit after the window is not a veto.
- R3: After a valid candidate, a delayed hit is either `hitBot` high, or `hitMid` high in a cycle that comes after some cycle from t0+1 onward in which `hitMid` was low. A middle input that stays high since the prompt never counts as a delayed hit.
- R4: A delayed hit at cycle td counts only when MIN_DELAY <= td-t0 <= ACCEPT_WIN. Hits with a smaller delay are ignored. If no hit qualifies by td-t0 = ACCEPT_WIN, the block returns to idle with no trigger.
- R5: On an accepted delayed hit at td, `trigOut` is high for exactly the one cycle td+1. In that same cycle `delayOut` equals td-t0, and it holds that value until the next trigger.
- R6: `busyOut` is high from cycle t0+1 until the block returns to idle. It is low in the cycle that carries the trigger pulse and in the cycle after the acceptance window expires. Prompt coincidences that arrive while busy neither restart the delay count nor open a new window.
- R7: With `rst` high at a clock edge, the block goes idle, and `trigOut`, `busyOut` and `delayOut` read zero after that edge. Any pending candidate is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hitTop | input | 1 | Top-plane hit level |
| hitMid | input | 1 | Middle-plane hit level |
| hitBot | input | 1 | Bottom-plane hit level |
| trigOut | output | 1 | One-cycle decay trigger |
| busyOut | output | 1 | Candidate in progress |
| delayOut | output | CNT_W | Cycles from prompt window opening to delayed hit |

## Verification
The prompt stage is driven with the middle hit lagging the top hit by zero cycles, by the last lag inside the window, and by one cycle past it. This separates a correct window width from an off-by-one one. Bottom hits are placed inside the window, just after it, and below the minimum delay. These cases separate the veto from the ignore rule. Delayed hits land exactly at the minimum delay, one cycle below it, exactly at the end of the acceptance window, and one cycle past it. Middle-plane patterns with a held level, a re-armed pulse and a second coincidence during the wait show whether the prompt pulse can retrigger itself, and whether the delay reference can be restarted.

// File: rtl/decay_trigger_pkg.sv
package decay_trigger_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROMPT = 2'd1,
    ST_WAIT   = 2'd2
  } trigState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;  // reload elapsed counter at window opening
    logic run;    // advance elapsed counter
    logic fire;   // latch delay and emit trigger
  } dpStrobe_t;

endpackage

// File: rtl/decay_trigger_ctrl.sv
module decay_trigger_ctrl
  import decay_trigger_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hitTop,
  input  logic      hitMid,
  input  logic      hitBot,
  input  logic      winLast,
  input  logic      minMet,
  input  logic      acceptLast,
  output dpStrobe_t strobe,
  output logic      busy
);

  trigState_t state, stateNext;
  logic seenTop, seenMid, seenBot;
  logic midArmed;
  logic promptOk, delayedHit;

  // a prompt candidate needs both upper planes and a clean bottom plane
  assign promptOk   = (seenTop | hitTop) & (seenMid | hitMid) & ~(seenBot | hitBot);
  // a middle hit counts only after the middle line has dropped once
  assign delayedHit = minMet & (hitBot | (hitMid & midArmed));

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    case (state)
      ST_IDLE: begin
        if (hitTop | hitMid) begin
          strobe.start = 1'b1;
          stateNext    = ST_PROMPT;
        end
      end
      ST_PROMPT: begin
        strobe.run = 1'b1;
        if (winLast) stateNext = promptOk ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: begin
        strobe.run = 1'b1;
        if (delayedHit) begin
          strobe.fire = 1'b1;
          stateNext   = ST_IDLE;
        end else if (acceptLast) begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      seenTop  <= 1'b0;
      seenMid  <= 1'b0;
      seenBot  <= 1'b0;
      midArmed <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE) begin
        seenTop  <= hitTop;
        seenMid  <= hitMid;
        seenBot  <= hitBot;
        midArmed <= 1'b0;
      end else begin
        if (state == ST_PROMPT) begin
          seenTop <= seenTop | hitTop;
          seenMid <= seenMid | hitMid;
          seenBot <= seenBot | hitBot;
        end
        if (!hitMid) midArmed <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  // R2: the wait phase is only ever entered through the prompt window
  assert_wait_from_prompt_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && $past(state) != ST_WAIT) |-> $past(state) == ST_PROMPT);

  // R4: no exit from the wait phase before the minimum delay has elapsed
  assert_no_early_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !minMet) |=> state == ST_WAIT);

  // R6: the datapath is never asked to restart while a candidate is pending
  assert_no_restart_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !strobe.start);

endmodule

// File: rtl/decay_trigger_datapath.sv
module decay_trigger_datapath
  import decay_trigger_pkg::*;
#(
  parameter int COINC_WIN  = 4,
  parameter int MIN_DELAY  = 8,
  parameter int ACCEPT_WIN = 5000,
  parameter int CNT_W      = $clog2(ACCEPT_WIN + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  output logic             winLast,
  output logic             minMet,
  output logic             acceptLast,
  output logic             trig,
  output logic [CNT_W-1:0] delay
);

  localparam logic [CNT_W-1:0] WIN_END    = CNT_W'(COINC_WIN - 1);
  localparam logic [CNT_W-1:0] MIN_CNT    = CNT_W'(MIN_DELAY);
  localparam logic [CNT_W-1:0] ACCEPT_END = CNT_W'(ACCEPT_WIN);

  // cycles since the prompt window opened
  logic [CNT_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      trig    <= 1'b0;
      delay   <= '0;
    end else begin
      if (strobe.start)    elapsed <= CNT_W'(1);
      else if (strobe.run) elapsed <= elapsed + CNT_W'(1);
      trig <= strobe.fire;
      if (strobe.fire) delay <= elapsed;
    end
  end

  assign winLast    = (elapsed == WIN_END);
  assign minMet     = (elapsed >= MIN_CNT);
  assign acceptLast = (elapsed == ACCEPT_END);

  // R4: the elapsed count never runs beyond the acceptance window while counting
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.run |-> elapsed <= ACCEPT_END);

endmodule

// File: rtl/decay_trigger.sv
module decay_trigger
  import decay_trigger_pkg::*;
#(
  parameter int COINC_WIN  = 4,
  parameter int MIN_DELAY  = 8,
  parameter int ACCEPT_WIN = 5000,
  parameter int CNT_W      = $clog2(ACCEPT_WIN + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hitTop,
  input  logic             hitMid,
  input  logic             hitBot,
  output logic             trigOut,
  output logic             busyOut,
  output logic [CNT_W-1:0] delayOut
);

  dpStrobe_t strobe;
  logic winLast, minMet, acceptLast;

  decay_trigger_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hitTop     (hitTop),
    .hitMid     (hitMid),
    .hitBot     (hitBot),
    .winLast    (winLast),
    .minMet     (minMet),
    .acceptLast (acceptLast),
    .strobe     (strobe),
    .busy       (busyOut)
  );

  decay_trigger_datapath #(
    .COINC_WIN  (COINC_WIN),
    .MIN_DELAY  (MIN_DELAY),
    .ACCEPT_WIN (ACCEPT_WIN),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .winLast    (winLast),
    .minMet     (minMet),
    .acceptLast (acceptLast),
    .trig       (trigOut),
    .delay      (delayOut)
  );

  // R5: the trigger is a single-cycle pulse
  assert_trig_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    trigOut |=> !trigOut);

  // R4: a reported delay always lies inside the accepted range
  assert_delay_range_R4: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> (delayOut >= CNT_W'(MIN_DELAY) && delayOut <= CNT_W'(ACCEPT_WIN)));

  // R6: the block is idle again in the trigger cycle
  assert_idle_on_trig_R6: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> !busyOut);

endmodule

// File: tb/tb_decay_trigger.sv
module tb_decay_trigger;

  localparam int PERIOD     = 10;
  localparam int COINC_WIN  = 4;
  localparam int MIN_DELAY  = 8;
  localparam int ACCEPT_WIN = 200;
  localparam int CNT_W      = $clog2(ACCEPT_WIN + 2);

  typedef struct {
    int    dly;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hitTop = 1'b0, hitMid = 1'b0, hitBot = 1'b0;
  logic trigOut, busyOut;
  logic [CNT_W-1:0] delayOut;

  int checks = 0;
  int fails  = 0;
  expItem_t expQ[$];

  always #(PERIOD/2) clk = ~clk;

  decay_trigger #(
    .COINC_WIN (COINC_WIN),
    .MIN_DELAY (MIN_DELAY),
    .ACCEPT_WIN(ACCEPT_WIN)
  ) dut (
    .clk(clk), .rst(rst), .hitTop(hitTop), .hitMid(hitMid), .hitBot(hitBot),
    .trigOut(trigOut), .busyOut(busyOut), .delayOut(delayOut)
  );

  task automatic check(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // monitor: every trigger pulse is matched against the scoreboard
  always @(negedge clk) begin
    if (!rst && trigOut) begin
      if (expQ.size() == 0) begin
        check("R5 unexpected trigger, delay", int'(delayOut), -1);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, int'(delayOut), it.dly);
      end
    end
  end

  // one scenario; cycle 0 is the window-opening cycle, delayed hits are 1-cycle pulses
  task automatic scen(input string tag, input int topLen, input int midLag, input int midLen,
                      input int botAt, input int botAt2, input int midAt2, input int topAt2,
                      input bit expTrig, input int expDelay, input bit busyChk);
    if (expTrig) expQ.push_back('{dly: expDelay, tag: tag});
    for (int c = 0; c < ACCEPT_WIN + 8; c++) begin
      hitTop = (c < topLen) || (c == topAt2);
      hitMid = (c >= midLag && c < midLag + midLen) || (c == midAt2);
      hitBot = (c == botAt) || (c == botAt2);
      @(posedge clk);
      @(negedge clk);
      if (busyChk && c == ACCEPT_WIN - 1) check({tag, " busy before expiry"}, int'(busyOut), 1);
      if (busyChk && c == ACCEPT_WIN)     check({tag, " busy after expiry"}, int'(busyOut), 0);
    end
    hitTop = 0; hitMid = 0; hitBot = 0;
    repeat (4) @(negedge clk);
    check({tag, " pending triggers"}, expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check("R7 trig after reset", int'(trigOut), 0);
    check("R7 busy after reset", int'(busyOut), 0);
    check("R7 delay after reset", int'(delayOut), 0);

    scen("R1 R3 simultaneous prompt, bottom decay", 3, 0, 3, 50, -1, -1, -1, 1, 50, 0);
    scen("R1 mid at last window cycle, mid decay",  3, 3, 3, -1, -1, 120, -1, 1, 120, 0);
    scen("R1 mid one cycle late",                   3, 4, 3, 50, -1, -1, -1, 0, 0, 0);
    scen("R2 bottom inside window vetoes",          3, 0, 3, 2, 50, -1, -1, 0, 0, 0);
    scen("R2 R4 bottom after window ignored",       3, 0, 3, 4, 60, -1, -1, 1, 60, 0);
    scen("R4 R6 below minimum then expiry",         3, 0, 3, MIN_DELAY-1, -1, -1, -1, 0, 0, 1);
    scen("R4 bottom at minimum delay",              3, 0, 3, MIN_DELAY, -1, -1, -1, 1, MIN_DELAY, 0);
    scen("R3 re-armed mid at minimum delay",        3, 0, 3, -1, -1, MIN_DELAY, -1, 1, MIN_DELAY, 0);
    scen("R4 bottom at window end",                 3, 0, 3, ACCEPT_WIN, -1, -1, -1, 1, ACCEPT_WIN, 0);
    scen("R4 bottom one past window end",           3, 0, 3, ACCEPT_WIN+1, -1, -1, -1, 0, 0, 0);
    scen("R3 held mid never counts",                3, 0, 16, -1, -1, -1, -1, 0, 0, 0);
    scen("R3 mid after release counts",             3, 0, 16, -1, -1, 30, -1, 1, 30, 0);
    scen("R6 second prompt while busy ignored",     3, 0, 26, 60, -1, -1, 20, 1, 60, 0);

    // R5: delay holds its value after the trigger pulse (last trigger had delay 60)
    check("R5 delay held after trigger", int'(delayOut), 60);

    // R7: reset in the middle of a wait discards the candidate
    hitTop = 1; hitMid = 1;
    @(negedge clk);
    hitTop = 0; hitMid = 0;
    repeat (10) @(negedge clk);
    check("R6 busy during wait", int'(busyOut), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 busy cleared by reset", int'(busyOut), 0);
    check("R7 delay cleared by reset", int'(delayOut), 0);
    hitBot = 1;
    @(negedge clk);
    hitBot = 0;
    repeat (4) @(negedge clk);
    check("R7 no trigger after reset", int'(trigOut), 0);
    check("R7 still idle", int'(busyOut), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule